// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is an 8-bit asynchronous serial port placed behind a simple 32-bit word register interface. Software writes bytes into an 8-entry transmit queue, which a serializer sends as frames of one start bit, eight data bits (least significant first) and one or two stop bits. A receiver oversamples the input line at sixteen times the bit rate and pushes each good frame into an 8-entry receive queue. The bit period is set by a 16-bit divisor: one bit lasts divisor + 1 clock cycles.

Interrupts do not come from individual events. Each direction has a software-set level that is compared against the live queue occupancy. Transmit asks for service while its queue holds fewer bytes than its level. Receive asks for service while its queue holds more bytes than its level. An enable mask selects which of the two conditions drive the single interrupt output. Queue full and empty status appear in bit 31 of the two data registers, so a single read gives both data and status.

Register word offsets: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt mask, 0x14 pending (read-only), 0x18 divisor. A read is combinational on `bus_rdata`. Write and read side effects take place at the clock edge where `bus_valid` is high.

Top module: `wmark_uart`

## Requirements
- R1: After reset `txd` is 1 and `irq` is 0. Transmit data reads 0 (bit 31, full, clear). Receive data reads 0x8000_0000 (bit 31, empty, set). Transmit control, receive control, mask, pending and divisor all read 0.
- R2: Writing bits 7:0 to offset 0x00 queues a byte. With transmit enabled (transmit control bit 0 = 1), the byte is sent as a low start bit, 8 data bits LSB first and a high stop bit, each lasting divisor + 1 cycles. Queued frames follow one another with no idle gap (start to start = 10 bit periods).
- R3: With transmit control bit 1 = 1, each frame carries two stop bits, so back-to-back frames start 11 bit periods apart.
- R4: While transmit control bit 0 = 0, no new frame starts: queued bytes stay queued and `txd` stays 1.
- R5: After 8 queued bytes, bit 31 of offset 0x00 reads 1. A further write is discarded, and only the first 8 bytes are later sent.
- R6: With receive control bit 0 = 1, a received frame is read at offset 0x04 with the byte in bits 7:0 and bit 31 = 0. Each such read removes the byte, so bytes come out in arrival order. A read of the empty queue returns 0x8000_0000 and removes nothing.
- R7: While receive control bit 0 = 0, frames on `rxd` are ignored.
- R8: A frame that arrives while the receive queue holds 8 bytes is dropped. The 8 stored bytes are unchanged.
- R9: Pending bit 0 (offset 0x14) is 1 exactly while the transmit count is below the transmit level in transmit control bits 18:16. With a level of 1 it is set only when the queue is empty.
- R10: Pending bit 1 is 1 exactly while the receive count is above the receive level in receive control bits 18:16. With a level of 0, any stored byte sets it.
- R11: `irq` is the OR over the two pending bits of pending AND mask, where mask bit 0 is transmit and bit 1 is receive (offset 0x10).
- R12: A low pulse on `rxd` that has ended by the middle of the start bit is rejected as a false start. No byte is stored, and the next real frame is still received.
- R13: The control fields read back at their positions: level at bits 18:16, two-stop at bit 1, enable at bit 0. The mask reads back at bits 1:0 and the divisor at bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is the receive queue overflowing while the read side stays passive. It needs nine complete, correctly timed frames on `rxd` with no reads between them, and the check is then that the ninth frame left no trace. The bench does this with a bit-accurate line driver that paces each frame from the programmed divisor, followed by a drain of the queue in which every read is compared against the scoreboard of accepted bytes. A related case is the false start: a short low pulse must end before the receiver's mid-bit confirm sample, and a real frame is sent immediately afterwards to show the receiver went back to idle.

// File: rtl/wmu_pkg.sv
package wmu_pkg;
  localparam int DATA_W     = 8;
  localparam int FIFO_DEPTH = 8;
  localparam int DIV_W      = 16;
  localparam int LVL_W      = 3;
  localparam int OS_SHIFT   = 4;   // 16x oversampling
  localparam int LVL_LSB    = 16;

  // word indices (bus_addr[4:2])
  localparam logic [2:0] W_TXDATA = 3'd0;
  localparam logic [2:0] W_RXDATA = 3'd1;
  localparam logic [2:0] W_TXCTRL = 3'd2;
  localparam logic [2:0] W_RXCTRL = 3'd3;
  localparam logic [2:0] W_MASK   = 3'd4;
  localparam logic [2:0] W_PEND   = 3'd5;
  localparam logic [2:0] W_DIV    = 3'd6;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // clock cycles per oversampling tick, at least one
  function automatic logic [DIV_W-1:0] os_period(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] p;
    p = ({1'b0, d} + 1'b1) >> OS_SHIFT;
    if (p == '0) return {{(DIV_W-1){1'b0}}, 1'b1};
    return p[DIV_W-1:0];
  endfunction

  function automatic logic tx_wm(input int cnt, input int lvl);
    return cnt < lvl;
  endfunction

  function automatic logic rx_wm(input int cnt, input int lvl);
    return cnt > lvl;
  endfunction
endpackage

// File: rtl/wmu_fifo.sv
module wmu_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R5 R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (count <= $past(count)));
  // R5 R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/wmu_tx.sv
module wmu_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             two_stop,
  input  logic [DIV_W-1:0] div,
  input  logic             q_empty,
  input  logic [7:0]       q_head,
  output logic             q_pop,
  output logic             txd
);
  localparam int FRAME_W = 11;   // start + 8 data + up to 2 stop

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         bits_left;
  logic [DIV_W-1:0]   bit_cnt;
  logic               busy;
  logic               frame_end;

  // last cycle of the last stop bit: next frame may load seamlessly
  assign frame_end = busy && (bit_cnt == '0) && (bits_left == 4'd1);
  assign q_pop     = en && !q_empty && (!busy || frame_end);
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      bit_cnt   <= '0;
    end else if (q_pop) begin
      busy      <= 1'b1;
      shreg     <= {2'b11, q_head, 1'b0};
      bits_left <= two_stop ? 4'd11 : 4'd10;
      bit_cnt   <= div;
    end else if (busy) begin
      if (bit_cnt == '0) begin
        if (bits_left == 4'd1) begin
          busy <= 1'b0;
        end else begin
          shreg     <= {1'b1, shreg[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
          bit_cnt   <= div;
        end
      end else begin
        bit_cnt <= bit_cnt - 1'b1;
      end
    end
  end

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> !txd);
  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !busy) |=> txd);
endmodule

// File: rtl/wmu_rx.sv
module wmu_rx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             push,
  output logic [7:0]       data
);
  import wmu_pkg::*;

  logic             sync1, sync2;
  rx_state_e        state;
  logic [DIV_W-1:0] tick_cnt;
  logic [DIV_W-1:0] tick_per;
  logic             tick;
  logic [3:0]       os_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shr;
  logic             push_q;

  assign tick_per = os_period(div);
  assign tick     = (state != RX_IDLE) && (tick_cnt == tick_per - 1'b1);
  assign push     = push_q;
  assign data     = shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      tick_cnt <= '0;
      os_cnt   <= '0;
      bit_idx  <= '0;
      shr      <= '0;
      push_q   <= 1'b0;
    end else begin
      push_q   <= 1'b0;
      tick_cnt <= (state == RX_IDLE || tick) ? '0 : tick_cnt + 1'b1;
      if (!en) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: if (!sync2) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
          RX_START: if (tick) begin
            if (os_cnt == 4'd7) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              state   <= sync2 ? RX_IDLE : RX_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          RX_DATA: if (tick) begin
            if (os_cnt == 4'd15) begin
              os_cnt  <= '0;
              shr     <= {sync2, shr[7:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == 3'd7) state <= RX_STOP;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          RX_STOP: if (tick) begin
            if (os_cnt == 4'd15) begin
              state  <= RX_IDLE;
              push_q <= sync2;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R6
  single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
  // R7
  rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == RX_IDLE));
endmodule

// File: rtl/wmark_uart.sv
module wmark_uart #(
  parameter int DEPTH = wmu_pkg::FIFO_DEPTH,
  parameter int DIV_W = wmu_pkg::DIV_W,
  parameter int LVL_W = wmu_pkg::LVL_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        irq
);
  import wmu_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  // control state
  logic             tx_en, tx_two, rx_en;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [1:0]       mask;
  logic [DIV_W-1:0] div_q;

  // queue and datapath wires
  logic [7:0]    txq_head, rxq_head, rx_byte;
  logic [CW-1:0] txq_cnt, rxq_cnt;
  logic          txq_full, txq_empty, rxq_full, rxq_empty;
  logic          txq_pop, rx_push;
  logic          wr_ev, rd_ev, txq_push, rxq_pop;
  logic [2:0]    word;
  logic          tx_hit, rx_hit;
  logic [1:0]    pend;
  logic          unused_bits;

  assign word        = bus_addr[4:2];
  assign wr_ev       = bus_valid && bus_write;
  assign rd_ev       = bus_valid && !bus_write;
  assign txq_push    = wr_ev && (word == W_TXDATA);
  assign rxq_pop     = rd_ev && (word == W_RXDATA);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:LVL_LSB+LVL_W],
                         rxq_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      tx_two <= 1'b0;
      tx_lvl <= '0;
      rx_en  <= 1'b0;
      rx_lvl <= '0;
      mask   <= '0;
      div_q  <= '0;
    end else if (wr_ev) begin
      case (word)
        W_TXCTRL: begin
          tx_en  <= bus_wdata[0];
          tx_two <= bus_wdata[1];
          tx_lvl <= bus_wdata[LVL_LSB +: LVL_W];
        end
        W_RXCTRL: begin
          rx_en  <= bus_wdata[0];
          rx_lvl <= bus_wdata[LVL_LSB +: LVL_W];
        end
        W_MASK:  mask  <= bus_wdata[1:0];
        W_DIV:   div_q <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  wmu_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(txq_push), .wdata(bus_wdata[7:0]),
    .pop(txq_pop), .head(txq_head), .count(txq_cnt),
    .full(txq_full), .empty(txq_empty));

  wmu_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
    .pop(rxq_pop), .head(rxq_head), .count(rxq_cnt),
    .full(rxq_full), .empty(rxq_empty));

  wmu_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .two_stop(tx_two), .div(div_q),
    .q_empty(txq_empty), .q_head(txq_head), .q_pop(txq_pop), .txd(txd));

  wmu_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div_q), .rxd(rxd),
    .push(rx_push), .data(rx_byte));

  assign tx_hit = tx_wm(int'(txq_cnt), int'(tx_lvl));
  assign rx_hit = rx_wm(int'(rxq_cnt), int'(rx_lvl));
  assign pend   = {rx_hit, tx_hit};
  assign irq    = |(pend & mask);

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_TXDATA: bus_rdata[31] = txq_full;
      W_RXDATA: begin
        bus_rdata[31]  = rxq_empty;
        bus_rdata[7:0] = rxq_empty ? 8'h00 : rxq_head;
      end
      W_TXCTRL: begin
        bus_rdata[LVL_LSB +: LVL_W] = tx_lvl;
        bus_rdata[1]                = tx_two;
        bus_rdata[0]                = tx_en;
      end
      W_RXCTRL: begin
        bus_rdata[LVL_LSB +: LVL_W] = rx_lvl;
        bus_rdata[0]                = rx_en;
      end
      W_MASK:  bus_rdata[1:0]       = mask;
      W_PEND:  bus_rdata[1:0]       = pend;
      W_DIV:   bus_rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  // R9
  tx_empty_wm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl == LVL_W'(1) && tx_hit) |-> (txq_cnt == '0));
  // R10
  rx_any_wm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == '0 && !rxq_empty) |-> rx_hit);
  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq);
  // R6
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_pop && !rxq_empty && !rx_push) |=> (rxq_cnt == $past(rxq_cnt) - 1'b1));
endmodule

// File: tb/sim_wmark_uart.sv
`timescale 1ns/1ps
module sim_wmark_uart;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd;
  logic        rxd = 1'b1;
  logic        irq;

  always #2.5 clk = ~clk;   // 200 MHz

  wmark_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq(irq));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int bit_cyc = 32;
  bit two_stop_exp = 1'b0;
  int tx_frames = 0;
  bit finished = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  int start_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp,
                        input string tag);
    logic [31:0] v;
    bus_rd(a, v);
    chk(v === exp, tag, v, exp);
  endtask

  // driver: queue a transmit byte, recording it in the scoreboard if kept
  task automatic tx_send(input logic [7:0] b, input bit kept);
    if (kept) exp_tx.push_back(b);
    bus_wr(5'h00, {24'h0, b});
  endtask

  task automatic tx_drain();
    while (exp_tx.size() != 0) @(negedge clk);
    repeat (2 * bit_cyc) @(negedge clk);
  endtask

  // line driver for the receiver
  task automatic rx_frame(input logic [7:0] b, input bit kept);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bit_cyc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bit_cyc) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bit_cyc) @(negedge clk);
    if (kept) exp_rx.push_back(b);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_read(input string tag);
    logic [31:0] v;
    logic [31:0] e;
    bus_rd(5'h04, v);
    e = (exp_rx.size() != 0) ? {24'h0, exp_rx.pop_front()} : 32'h8000_0000;
    chk(v === e, tag, v, e);
  endtask

  // monitor: decode frames on txd and compare against the scoreboard
  initial begin
    logic prev;
    logic [7:0] b;
    logic [7:0] e;
    prev = 1'b1;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (prev && !txd) begin
        start_q.push_back(cyc);
        repeat (bit_cyc / 2) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit", {31'h0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_cyc) @(negedge clk);
          b[i] = txd;
        end
        repeat (bit_cyc) @(negedge clk);
        chk(txd == 1'b1, "R2 stop bit", {31'h0, txd}, 32'h1);
        if (two_stop_exp) begin
          repeat (bit_cyc) @(negedge clk);
          chk(txd == 1'b1, "R3 second stop bit", {31'h0, txd}, 32'h1);
        end
        tx_frames++;
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R5 unexpected frame", {24'h0, b}, 32'h0);
        end else begin
          e = exp_tx.pop_front();
          chk(b === e, "R2 frame data", {24'h0, b}, {24'h0, e});
        end
        prev = txd;
      end else begin
        prev = txd;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    logic [31:0] v;
    bit bad;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd idle", {31'h0, txd}, 32'h1);
    chk(irq === 1'b0, "R1 irq low", {31'h0, irq}, 32'h0);
    rd_chk(5'h00, 32'h0, "R1 tx data");
    rd_chk(5'h04, 32'h8000_0000, "R1 rx data");
    rd_chk(5'h08, 32'h0, "R1 tx ctrl");
    rd_chk(5'h0C, 32'h0, "R1 rx ctrl");
    rd_chk(5'h10, 32'h0, "R1 mask");
    rd_chk(5'h14, 32'h0, "R1 pending");
    rd_chk(5'h18, 32'h0, "R1 divisor");

    // R13 field readback
    bus_wr(5'h08, 32'h0003_0002);
    rd_chk(5'h08, 32'h0003_0002, "R13 tx ctrl");
    bus_wr(5'h0C, 32'h0005_0000);
    rd_chk(5'h0C, 32'h0005_0000, "R13 rx ctrl");
    bus_wr(5'h10, 32'h3);
    rd_chk(5'h10, 32'h3, "R13 mask");
    bus_wr(5'h10, 32'h0);
    bus_wr(5'h18, 32'd31);
    rd_chk(5'h18, 32'd31, "R13 divisor");
    bus_wr(5'h0C, 32'h0);

    // R9 tx watermark, transmit disabled
    bus_wr(5'h08, 32'h0001_0000);
    rd_chk(5'h14, 32'h1, "R9 level1 empty");
    tx_send(8'h5A, 1'b1);
    rd_chk(5'h14, 32'h0, "R9 level1 one byte");
    bus_wr(5'h08, 32'h0003_0000);
    rd_chk(5'h14, 32'h1, "R9 level3 one byte");

    // R4 nothing leaves while disabled
    bad = 1'b0;
    for (int i = 0; i < 3 * bit_cyc; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad = 1'b1;
    end
    chk(!bad, "R4 line held idle", {31'h0, bad}, 32'h0);
    chk(tx_frames == 0, "R4 no frame", tx_frames, 0);

    // R2 enable, back-to-back one-stop frames
    start_q.delete();
    tx_send(8'hC3, 1'b1);
    tx_send(8'h01, 1'b1);
    bus_wr(5'h08, 32'h0000_0001);
    tx_drain();
    chk(start_q.size() == 3, "R2 frame count", start_q.size(), 3);
    if (start_q.size() >= 2)
      chk(start_q[1] - start_q[0] == 10 * bit_cyc, "R2 frame spacing",
          start_q[1] - start_q[0], 10 * bit_cyc);

    // R3 two stop bits
    bus_wr(5'h08, 32'h0000_0003);
    two_stop_exp = 1'b1;
    start_q.delete();
    tx_send(8'h96, 1'b1);
    tx_send(8'h3C, 1'b1);
    tx_drain();
    if (start_q.size() >= 2)
      chk(start_q[1] - start_q[0] == 11 * bit_cyc, "R3 frame spacing",
          start_q[1] - start_q[0], 11 * bit_cyc);
    else
      chk(1'b0, "R3 frame count", start_q.size(), 2);
    two_stop_exp = 1'b0;

    // R2 shorter bit period
    bus_wr(5'h08, 32'h0000_0001);
    bus_wr(5'h18, 32'd15);
    bit_cyc = 16;
    tx_send(8'hE7, 1'b1);
    tx_drain();
    bus_wr(5'h18, 32'd31);
    bit_cyc = 32;

    // R5 full flag and discarded write
    bus_wr(5'h08, 32'h0000_0000);
    for (int i = 0; i < 8; i++) tx_send(8'h10 + 8'(i), 1'b1);
    rd_chk(5'h00, 32'h8000_0000, "R5 full flag");
    tx_send(8'hFF, 1'b0);
    base = tx_frames;
    bus_wr(5'h08, 32'h0000_0001);
    tx_drain();
    repeat (12 * bit_cyc) @(negedge clk);
    chk(tx_frames - base == 8, "R5 only eight sent", tx_frames - base, 8);
    rd_chk(5'h00, 32'h0, "R5 full cleared");

    // R6 receive in order
    bus_wr(5'h0C, 32'h0000_0001);
    rx_frame(8'hA5, 1'b1);
    rx_frame(8'h3E, 1'b1);
    rx_read("R6 first byte");
    rx_read("R6 second byte");
    rx_read("R6 empty read");

    // R10 R11 watermarks and mask
    bus_wr(5'h08, 32'h0000_0000);
    bus_wr(5'h10, 32'h2);
    @(negedge clk);
    chk(irq === 1'b0, "R11 irq rx empty", {31'h0, irq}, 32'h0);
    rx_frame(8'h77, 1'b1);
    rd_chk(5'h14, 32'h2, "R10 level0 any byte");
    @(negedge clk);
    chk(irq === 1'b1, "R11 irq rx pending", {31'h0, irq}, 32'h1);
    bus_wr(5'h10, 32'h0);
    @(negedge clk);
    chk(irq === 1'b0, "R11 irq masked", {31'h0, irq}, 32'h0);
    bus_wr(5'h10, 32'h1);
    @(negedge clk);
    chk(irq === 1'b0, "R11 tx level0", {31'h0, irq}, 32'h0);
    bus_wr(5'h08, 32'h0001_0001);
    @(negedge clk);
    chk(irq === 1'b1, "R11 tx pending", {31'h0, irq}, 32'h1);
    bus_wr(5'h10, 32'h0);
    bus_wr(5'h0C, 32'h0002_0001);
    rx_frame(8'h78, 1'b1);
    rd_chk(5'h14, 32'h1, "R10 two not above two");
    rx_frame(8'h79, 1'b1);
    rd_chk(5'h14, 32'h3, "R10 three above two");
    rx_read("R10 drain a");
    rd_chk(5'h14, 32'h1, "R10 back to two");
    rx_read("R10 drain b");
    rx_read("R10 drain c");

    // R7 receiver disabled
    bus_wr(5'h0C, 32'h0);
    rx_frame(8'h55, 1'b0);
    rx_read("R7 ignored frame");

    // R12 false start
    bus_wr(5'h0C, 32'h0000_0001);
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (12 * bit_cyc) @(negedge clk);
    rx_read("R12 glitch rejected");
    rx_frame(8'h81, 1'b1);
    rx_read("R12 next frame");

    // R8 overflow drop
    for (int i = 0; i < 9; i++) rx_frame(8'h20 + 8'(i), i < 8);
    for (int i = 0; i < 9; i++) rx_read("R8 overflow readout");

    summary();
  end
endmodule